// File: doc/BRIEF.md
# Dual-Edge Delay Tuning Sequencer

This block runs a calibration sweep for one sampled input path of a card host: either the command-response path or the read-data path. After a start strobe it programs a sampling edge and a 5-bit input delay. At each setting it asks an external test engine for one test transaction and records whether that transaction came back clean. The rising edge is swept over every delay tap first, then the falling edge. The outcome is two 32-bit pass maps, one for each edge.

When the sweep ends, a window finder looks at each map for its widest run of passing taps and derives a recommended tap from it. A picker then chooses the edge. The chosen edge and tap are left on the edge and delay outputs, and a done pulse marks the result as valid. If neither edge passed anywhere, the block reports a failed tuning attempt. A single mode input chooses between command tuning and data tuning. In data mode the write-data sampling edge follows the read-data edge, and the rising edge is favoured when its window is wide enough.

Top module: `delay_tune_seq`

## Requirements
- R1: After a start, the block issues exactly 64 single-cycle `test_req_o` pulses. The first 32 are on the rising edge (`rd_edge_fall_o`=0) at delays 0,1,…,31, and the last 32 are on the falling edge (`rd_edge_fall_o`=1) at delays 0,1,…,31.
- R2: Bit i of `rise_map_o` (or `fall_map_o`) is 1 only when the test at delay i on that edge ended with `test_done_i`=1 and `test_pass_i`=1. Otherwise the bit is 0.
- R3: The window of an edge is its longest run of consecutive passing taps. The search scans from tap 0 upward, keeps the first of equal-length runs, and does not wrap past tap 31. It stops early at the first run of 8 or more taps once the best run so far starts below tap 4. The edge with the longer window wins, and a tie goes to the rising edge.
- R4: In data mode (`data_mode_i`=1 at start), a rising window of 10 taps or more selects the rising edge, whatever the falling window is.
- R5: In data mode `wr_edge_fall_o` equals `rd_edge_fall_o`. In command mode it is 0.
- R6: The recommended tap is start+len/3 when the window starts at tap 0, and start+len/2 otherwise (integer division). When `done_o` pulses, `dly_o` and `rd_edge_fall_o` show the chosen tap and edge.
- R7: When both maps are empty, `fail_o` is 1 at `done_o`, with `dly_o`=0 and the rising edge selected. Otherwise `fail_o` is 0.
- R8: `dly_o` and `rd_edge_fall_o` hold steady from a `test_req_o` pulse until that test's `test_done_i`.
- R9: A test that gets no `test_done_i` within `TMO_CYCLES` cycles is recorded as a failure at that tap, and the sweep continues.
- R10: `start_i` is ignored while `busy_o`=1, and the mode is latched at start. `done_o` is a one-cycle pulse after the last test, with `busy_o` already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a sweep (taken only when idle) |
| data_mode_i | input | 1 | 1 = data tuning, 0 = command tuning; latched at start |
| test_req_o | output | 1 | One-cycle request for a test transaction |
| test_done_i | input | 1 | Test transaction finished |
| test_pass_i | input | 1 | Test finished without error (valid with done) |
| rd_edge_fall_o | output | 1 | Sampling edge for the tuned path, 1 = falling |
| wr_edge_fall_o | output | 1 | Write-data sampling edge, follows the read edge in data mode |
| dly_o | output | 5 | Input delay tap |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| fail_o | output | 1 | No passing tap on either edge |
| rise_map_o | output | 32 | Pass map of the rising-edge sweep |
| fall_map_o | output | 32 | Pass map of the falling-edge sweep |

## Verification
Two events can land on the same clock cycle. One is the completion of a test, which advances the tap. The other is a fresh start strobe, which must not restart or re-mode the sweep. The bench drives `start_i` high on the very cycle it returns the done of the 21st test of a data-mode sweep, with command mode on the mode input. It judges the result by the request count (still 64), the tap order, and a result that still follows the data-mode rules, including the write edge. A second concurrency, a test timeout and the tap advance, is covered by withholding one reply and checking that the sweep resumes at the next tap with that bit cleared.

// File: rtl/tune_pkg.sv
// Package: shared state encoding and edge codes for the delay tuning sequencer.
// Assumes: no parameters needed here; widths stay on the modules.
package tune_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_EVAL
    } tune_state_e;

    localparam logic EDGE_RISE = 1'b0;
    localparam logic EDGE_FALL = 1'b1;
endpackage

// File: rtl/tune_window_finder.sv
// Module: finds the widest passing window in a tap pass map and recommends a tap.
// Scans from tap 0 upward with no wrap, keeps the first of equal runs, and stops
// at the first run of EARLY_LEN or more taps once the best start is below EARLY_START.
// Assumes: purely combinational; an empty map yields length 0 and an all-ones phase.
module tune_window_finder #(
    parameter int NTAP        = 32,
    parameter int LEN_W       = 6,
    parameter int PH_W        = 8,
    parameter int EARLY_LEN   = 8,
    parameter int EARLY_START = 4
) (
    input  logic [NTAP-1:0]  map_i,
    output logic [LEN_W-1:0] len_o,
    output logic [PH_W-1:0]  phase_o
);
    // Run-length scan over the map with an early stop.
    always_comb begin
        int  cur_len;
        int  cur_start;
        int  best_len;
        int  best_start;
        logic stop;
        cur_len    = 0;
        cur_start  = 0;
        best_len   = 0;
        best_start = 0;
        stop       = 1'b0;
        for (int i = 0; i < NTAP; i++) begin
            if (!stop) begin
                if (map_i[i]) begin
                    if (cur_len == 0) cur_start = i;
                    cur_len = cur_len + 1;
                end
                if (!map_i[i] || i == NTAP - 1) begin
                    if (cur_len > best_len) begin
                        best_len   = cur_len;
                        best_start = cur_start;
                    end
                    if (cur_len >= EARLY_LEN && best_start < EARLY_START) stop = 1'b1;
                    cur_len = 0;
                end
            end
        end
        len_o = LEN_W'(best_len);
        if (best_len == 0)
            phase_o = '1;
        else if (best_start == 0)
            phase_o = PH_W'(best_len / 3);
        else
            phase_o = PH_W'((best_start + best_len / 2) % NTAP);
    end

    // Guards on the finder output.
    always_comb begin
        // R3
        win_len_bound_chk: assert (int'(len_o) <= $countones(map_i));
        // R7
        empty_code_chk: assert ((len_o == '0) == (phase_o == '1));
    end
endmodule

// File: rtl/tune_edge_pick.sv
// Module: chooses the sampling edge from the two window lengths and gives the final tap.
// The wider window wins, a tie goes to rising, and in data mode a rising window of
// PREF_LEN or more taps forces rising. A phase of all ones means the attempt failed.
// Assumes: inputs come straight from the two window finders.
module tune_edge_pick #(
    parameter int LEN_W    = 6,
    parameter int PH_W     = 8,
    parameter int DLY_W    = 5,
    parameter int PREF_LEN = 10
) (
    input  logic             data_mode_i,
    input  logic [LEN_W-1:0] rise_len_i,
    input  logic [LEN_W-1:0] fall_len_i,
    input  logic [PH_W-1:0]  rise_phase_i,
    input  logic [PH_W-1:0]  fall_phase_i,
    output logic             pick_fall_o,
    output logic [DLY_W-1:0] pick_dly_o,
    output logic             pick_fail_o
);
    logic            rise_pref;
    logic [PH_W-1:0] sel_phase;

    // Edge choice and failure detection.
    always_comb begin
        rise_pref   = data_mode_i && (rise_len_i >= LEN_W'(PREF_LEN));
        pick_fall_o = (fall_len_i > rise_len_i) && !rise_pref;
        sel_phase   = pick_fall_o ? fall_phase_i : rise_phase_i;
        pick_fail_o = (sel_phase == '1);
        pick_dly_o  = pick_fail_o ? '0 : sel_phase[DLY_W-1:0];
    end

    // Guards on the edge choice.
    always_comb begin
        // R3
        wider_wins_chk: assert (!pick_fall_o || (fall_len_i > rise_len_i));
        // R4
        rise_pref_chk: assert (!(data_mode_i && rise_len_i >= LEN_W'(PREF_LEN)) || !pick_fall_o);
    end
endmodule

// File: rtl/tune_sweep_ctrl.sv
// Module: sweep controller. Steps edge and delay through both sweeps, requests one
// test per setting, records pass/fail, applies a timeout, then loads the final pick.
// Assumes: test_done_i is only honoured while waiting for a test; start_i only when idle.
module tune_sweep_ctrl
    import tune_pkg::*;
#(
    parameter int NTAP       = 32,
    parameter int DLY_W      = 5,
    parameter int TMO_CYCLES = 256
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             start_i,
    input  logic             data_mode_i,
    input  logic             test_done_i,
    input  logic             test_pass_i,
    input  logic             pick_fall_i,
    input  logic [DLY_W-1:0] pick_dly_i,
    input  logic             pick_fail_i,
    output logic             test_req_o,
    output logic             edge_o,
    output logic             wr_edge_o,
    output logic [DLY_W-1:0] dly_o,
    output logic             mode_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o,
    output logic [NTAP-1:0]  map_rise_o,
    output logic [NTAP-1:0]  map_fall_o
);
    localparam int              TMR_W    = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TMO_CYCLES - 1);
    localparam logic [DLY_W-1:0] DLY_LAST = '1;

    tune_state_e      st_q;
    logic             edge_q;
    logic [DLY_W-1:0] dly_q;
    logic             mode_q;
    logic             done_q;
    logic             fail_q;
    logic [TMR_W-1:0] tmr_q;
    logic [NTAP-1:0]  map_r_q;
    logic [NTAP-1:0]  map_f_q;
    logic             finish_test;
    logic             test_ok;

    // A test ends on its done pulse or when its timer runs out.
    always_comb begin
        finish_test = (st_q == ST_WAIT) && (test_done_i || tmr_q == TMR_LAST);
        test_ok     = test_done_i && test_pass_i;
    end

    // Sequencer state, tap stepping, map recording and result loading.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            st_q    <= ST_IDLE;
            edge_q  <= EDGE_RISE;
            dly_q   <= '0;
            mode_q  <= 1'b0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            tmr_q   <= '0;
            map_r_q <= '0;
            map_f_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q    <= ST_REQ;
                        edge_q  <= EDGE_RISE;
                        dly_q   <= '0;
                        mode_q  <= data_mode_i;
                        fail_q  <= 1'b0;
                        map_r_q <= '0;
                        map_f_q <= '0;
                    end
                end
                ST_REQ: begin
                    st_q  <= ST_WAIT;
                    tmr_q <= '0;
                end
                ST_WAIT: begin
                    if (finish_test) begin
                        if (edge_q == EDGE_RISE) map_r_q[dly_q] <= test_ok;
                        else                     map_f_q[dly_q] <= test_ok;
                        if (edge_q == EDGE_FALL && dly_q == DLY_LAST) begin
                            st_q <= ST_EVAL;
                        end else begin
                            st_q <= ST_REQ;
                            if (dly_q == DLY_LAST) begin
                                edge_q <= EDGE_FALL;
                                dly_q  <= '0;
                            end else begin
                                dly_q <= dly_q + DLY_W'(1);
                            end
                        end
                    end else begin
                        tmr_q <= tmr_q + TMR_W'(1);
                    end
                end
                ST_EVAL: begin
                    edge_q <= pick_fall_i;
                    dly_q  <= pick_dly_i;
                    fail_q <= pick_fail_i;
                    done_q <= 1'b1;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign test_req_o = (st_q == ST_REQ);
    assign edge_o     = edge_q;
    assign wr_edge_o  = mode_q & edge_q;
    assign dly_o      = dly_q;
    assign mode_o     = mode_q;
    assign busy_o     = (st_q != ST_IDLE);
    assign done_o     = done_q;
    assign fail_o     = fail_q;
    assign map_rise_o = map_r_q;
    assign map_fall_o = map_f_q;

    // R8
    tap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_q == ST_WAIT) |-> ($stable(dly_q) && $stable(edge_q)));
    // R1
    edge_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_q == ST_REQ && $rose(edge_q)) |-> (dly_q == '0 && $past(dly_q) == DLY_LAST));
    // R1
    req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        test_req_o |=> !test_req_o);
    // R10
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        done_q |=> !done_q);
    // R10
    done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        done_q |-> !busy_o);
endmodule

// File: rtl/delay_tune_seq.sv
// Module: top of the dual-edge delay tuning sequencer. Ties the sweep controller
// to one window finder for each edge and to the edge picker.
// Assumes: the external test engine answers each test_req_o with one test_done_i pulse.
module delay_tune_seq #(
    parameter int DLY_W       = 5,
    parameter int TMO_CYCLES  = 256,
    parameter int PREF_LEN    = 10,
    parameter int EARLY_LEN   = 8,
    parameter int EARLY_START = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_n_i,
    input  logic                  start_i,
    input  logic                  data_mode_i,
    output logic                  test_req_o,
    input  logic                  test_done_i,
    input  logic                  test_pass_i,
    output logic                  rd_edge_fall_o,
    output logic                  wr_edge_fall_o,
    output logic [DLY_W-1:0]      dly_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  fail_o,
    output logic [(1<<DLY_W)-1:0] rise_map_o,
    output logic [(1<<DLY_W)-1:0] fall_map_o
);
    localparam int NTAP  = 1 << DLY_W;
    localparam int LEN_W = $clog2(NTAP + 1);
    localparam int PH_W  = DLY_W + 3;

    logic [1:0][NTAP-1:0]  maps;
    logic [1:0][LEN_W-1:0] lens;
    logic [1:0][PH_W-1:0]  phases;
    logic                  mode;
    logic                  pick_fall;
    logic [DLY_W-1:0]      pick_dly;
    logic                  pick_fail;

    tune_sweep_ctrl #(
        .NTAP      (NTAP),
        .DLY_W     (DLY_W),
        .TMO_CYCLES(TMO_CYCLES)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .start_i    (start_i),
        .data_mode_i(data_mode_i),
        .test_done_i(test_done_i),
        .test_pass_i(test_pass_i),
        .pick_fall_i(pick_fall),
        .pick_dly_i (pick_dly),
        .pick_fail_i(pick_fail),
        .test_req_o (test_req_o),
        .edge_o     (rd_edge_fall_o),
        .wr_edge_o  (wr_edge_fall_o),
        .dly_o      (dly_o),
        .mode_o     (mode),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .fail_o     (fail_o),
        .map_rise_o (maps[0]),
        .map_fall_o (maps[1])
    );

    // One window finder for each sampling edge.
    for (genvar e = 0; e < 2; e++) begin : g_find
        tune_window_finder #(
            .NTAP       (NTAP),
            .LEN_W      (LEN_W),
            .PH_W       (PH_W),
            .EARLY_LEN  (EARLY_LEN),
            .EARLY_START(EARLY_START)
        ) u_find (
            .map_i  (maps[e]),
            .len_o  (lens[e]),
            .phase_o(phases[e])
        );
    end

    tune_edge_pick #(
        .LEN_W   (LEN_W),
        .PH_W    (PH_W),
        .DLY_W   (DLY_W),
        .PREF_LEN(PREF_LEN)
    ) u_pick (
        .data_mode_i (mode),
        .rise_len_i  (lens[0]),
        .fall_len_i  (lens[1]),
        .rise_phase_i(phases[0]),
        .fall_phase_i(phases[1]),
        .pick_fall_o (pick_fall),
        .pick_dly_o  (pick_dly),
        .pick_fail_o (pick_fail)
    );

    assign rise_map_o = maps[0];
    assign fall_map_o = maps[1];

    // R5
    wr_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        mode ? (wr_edge_fall_o == rd_edge_fall_o) : !wr_edge_fall_o);
endmodule

// File: tb/delay_tune_seq_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, with a behavioural test responder.
module delay_tune_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_main = 1'b0;
    logic        start_aux = 1'b0;
    logic        mode_in = 1'b0;
    logic        test_done = 1'b0;
    logic        test_pass = 1'b0;
    logic        test_req;
    logic        rd_fall, wr_fall, busy, done, fail;
    logic [4:0]  dly;
    logic [31:0] rmap, fmap;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // responder controls (written by main) and counters (written by responder)
    logic [31:0] model_r = '0, model_f = '0;
    int  lat = 1;
    bit  drop_en = 0;
    bit  drop_edge = 0;
    int  drop_dly = 0;
    bit  collide_en = 0;
    int  base = 0;
    int  req_idx = 0;
    int  order_err = 0;
    int  stab_err = 0;

    always #2 clk = ~clk;

    delay_tune_seq #(.TMO_CYCLES(40)) u_dut (
        .clk_i(clk), .rst_n_i(rst_n), .start_i(start_main | start_aux),
        .data_mode_i(mode_in), .test_req_o(test_req), .test_done_i(test_done),
        .test_pass_i(test_pass), .rd_edge_fall_o(rd_fall), .wr_edge_fall_o(wr_fall),
        .dly_o(dly), .busy_o(busy), .done_o(done), .fail_o(fail),
        .rise_map_o(rmap), .fall_map_o(fmap)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog R10: cycles %0d expected below %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    // Test responder: answers each request after lat cycles, checks order and hold.
    initial begin
        forever begin
            @(negedge clk);
            if (test_done) begin
                test_done = 1'b0;
                test_pass = 1'b0;
                start_aux = 1'b0;
            end
            if (test_req) begin
                automatic bit e = rd_fall;
                automatic int d = int'(dly);
                automatic int k = req_idx - base;
                if (e != (k >= 32) || d != k % 32) order_err++;
                req_idx++;
                if (!(drop_en && e == drop_edge && d == drop_dly)) begin
                    for (int j = 0; j < lat; j++) begin
                        @(negedge clk);
                        if (rd_fall != e || int'(dly) != d) stab_err++;
                    end
                    test_pass = e ? model_f[d] : model_r[d];
                    test_done = 1'b1;
                    if (collide_en && (req_idx - base) == 21) start_aux = 1'b1;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one sweep and checks every result against hand-computed values.
    task automatic sweep(input bit md, input logic [31:0] mr, input logic [31:0] mf,
                         input logic [31:0] exp_r, input logic [31:0] exp_f,
                         input bit exp_fall, input int exp_dly, input bit exp_fail,
                         input string sel_tag);
        int o0, s0, n;
        bit seen;
        model_r = mr;
        model_f = mf;
        o0 = order_err;
        s0 = stab_err;
        @(negedge clk);
        base = req_idx;
        mode_in = md;
        start_main = 1'b1;
        @(negedge clk);
        start_main = 1'b0;
        mode_in = ~md;
        seen = 0;
        n = 0;
        while (!seen && n < 20000) begin
            @(negedge clk);
            n++;
            if (done) seen = 1;
        end
        chk("R10", "done pulse seen", seen, 1);
        chk("R10", "busy low at done", busy, 0);
        chk("R6", "final delay", dly, exp_dly);
        chk(sel_tag, "final edge", rd_fall, exp_fall);
        chk("R5", "write edge", wr_fall, md ? exp_fall : 1'b0);
        chk("R7", "fail flag", fail, exp_fail);
        chk("R2", "rise map", rmap, exp_r);
        chk("R2", "fall map", fmap, exp_f);
        chk("R1", "request count", req_idx - base, 64);
        chk("R1", "request order errors", order_err - o0, 0);
        chk("R8", "hold errors", stab_err - s0, 0);
        @(negedge clk);
        chk("R10", "done single cycle", done, 0);
    endtask

    task automatic t_reset();
        chk("R10", "reset test_req", test_req, 0);
        chk("R10", "reset busy", busy, 0);
        chk("R10", "reset done", done, 0);
        chk("R6", "reset delay", dly, 0);
        chk("R5", "reset edges", {rd_fall, wr_fall}, 0);
        chk("R7", "reset fail", fail, 0);
    endtask

    // Command mode: falling window 20 at tap 0 beats rising window 10 at tap 4.
    task automatic t_cmd_fall_wins();
        lat = 1;
        sweep(0, 32'h0000_3FF0, 32'h000F_FFFF, 32'h0000_3FF0, 32'h000F_FFFF, 1, 6, 0, "R3");
    endtask

    // Data mode: rising window exactly 10 forces rising, tap 4+5.
    task automatic t_data_rise_pref();
        lat = 2;
        sweep(1, 32'h0000_3FF0, 32'h000F_FFFF, 32'h0000_3FF0, 32'h000F_FFFF, 0, 9, 0, "R4");
    endtask

    // Data mode: rising window 9 is below the preference, falling wins, write edge follows.
    task automatic t_data_below_pref();
        lat = 1;
        sweep(1, 32'h0000_1FF0, 32'h000F_FFFF, 32'h0000_1FF0, 32'h000F_FFFF, 1, 6, 0, "R4");
    endtask

    // Equal windows of 8: rising kept, tap 10+4.
    task automatic t_tie();
        lat = 3;
        sweep(0, 32'h0003_FC00, 32'h0FF0_0000, 32'h0003_FC00, 32'h0FF0_0000, 0, 14, 0, "R3");
    endtask

    // Nothing passes: failure reported with tap 0 rising.
    task automatic t_empty();
        lat = 1;
        sweep(0, 32'h0, 32'h0, 32'h0, 32'h0, 0, 0, 1, "R7");
    endtask

    // Data mode, rising empty: falling window 4 at tap 20 gives 22.
    task automatic t_rise_empty();
        lat = 1;
        sweep(1, 32'h0, 32'h00F0_0000, 32'h0, 32'h00F0_0000, 1, 22, 0, "R3");
    endtask

    // Early stop: run of 8 at tap 2 ends the search before the run of 16 at 15.
    task automatic t_early_stop();
        lat = 1;
        sweep(0, 32'h7FFF_83FC, 32'h0, 32'h7FFF_83FC, 32'h0, 0, 6, 0, "R3");
    endtask

    // Every tap passes on both edges: tie, start 0, tap 32/3.
    task automatic t_full();
        lat = 1;
        sweep(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 10, 0, "R6");
    endtask

    // Window ending at tap 31 (no wrap into taps 0..2), tie of 12 keeps rising: 20+6.
    task automatic t_top_end();
        lat = 1;
        sweep(0, 32'hFFF0_0007, 32'h0000_FFF0, 32'hFFF0_0007, 32'h0000_FFF0, 0, 26, 0, "R6");
    endtask

    // Rising tap 5 never answers: timeout clears its bit, best run 6..31 gives 19.
    task automatic t_timeout();
        lat = 1;
        drop_en = 1;
        drop_edge = 0;
        drop_dly = 5;
        sweep(0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFDF, 32'h0, 0, 19, 0, "R9");
        drop_en = 0;
    endtask

    // Start in command mode lands with the 21st done of a data sweep: ignored.
    task automatic t_start_collide();
        lat = 1;
        collide_en = 1;
        sweep(1, 32'h0000_1FF0, 32'h000F_FFFF, 32'h0000_1FF0, 32'h000F_FFFF, 1, 6, 0, "R10");
        collide_en = 0;
        chk("R10", "idle after collide sweep", busy, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_fall_wins();
        t_data_rise_pref();
        t_data_below_pref();
        t_tie();
        t_empty();
        t_rise_empty();
        t_early_stop();
        t_full();
        t_top_end();
        t_timeout();
        t_start_collide();
        summary();
        $finish;
    end
endmodule